// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block watches a running calendar time made of BCD seconds, minutes, hours and day of month. It compares that time against a programmed alarm setting once per one-second strobe. Each alarm byte carries a repeat bit in its top position. A field whose repeat bit is set is left out of the comparison, so the same hardware can give a monthly, daily, hourly, per-minute or per-second alarm. A successful comparison sets a sticky alarm flag. When its enable is set, the flag also drives an interrupt line.

A separate enable decides whether matches still count while the system runs from its backup battery. Software programs the unit through a byte-wide register port. Reading the status register returns the flag and clears it, which also drops the interrupt. The time counters live outside this block and must present settled values whenever the strobe is high.

Top module: `tod_alarm`

## Requirements
- R1: After reset the alarm flag and interrupt are low, all four alarm bytes are zero and the control register reads 0x00.
- R2: A write with reg_wr high stores reg_wdata at reg_addr. Addresses 0, 1, 2 and 3 hold the alarm seconds, minutes, hours and day bytes, with the repeat bit in bit 7. Address 4 is control: bit 7 is the flag-to-interrupt enable and bit 5 is the battery-backup enable, and the other bits read 0. A read with reg_rd high puts the addressed value on reg_rdata in the next cycle, and reg_rdata then holds until the next read.
- R3: On a clock edge where tick is high and every non-repeat field matches, the alarm flag is set and is visible in the next cycle. A field matches when its low bits are equal: 7 bits for seconds and minutes, and 6 bits for hours and day. Bit 6 of the hours and day bytes is not compared.
- R4: While tick is low the flag is never set, whatever the current time is.
- R5: A field with its repeat bit (bit 7) set is ignored in the comparison. With all four repeat bits set, every tick sets the flag.
- R6: irq is high exactly when the flag is set and control bit 7 is set. With control bit 7 clear, the flag still sets but irq stays low.
- R7: While batt_mode is high and control bit 5 is clear, matches are ignored. With bit 5 set, matches in battery mode set the flag.
- R8: A read of address 5 (status) returns the flag in bit 6 with the other bits 0, and clears the flag and irq. If a match occurs in the same cycle as that read, the flag is set, and the read returns the value from before the match.
- R9: Once set, the flag stays set across later non-matching ticks until a status read clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second strobe, high for one cycle after the time has updated |
| batt_mode | input | 1 | High while running from the backup battery |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle after reg_rd |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench checks several corner cases:
- A seconds value one count short of the alarm, which an off-by-one comparator would accept.
- A fully matching time with no strobe, which a design that compares continuously would flag.
- Each repeat combination, including a seconds-only repeat with a wrong minute. A design that drops the wrong fields would fire there.
- The battery-mode gate on both settings of its enable.
- A status read in the same cycle as a match. A clear-priority design would lose that alarm.
- An hours byte with its unused bit 6 set, which a design comparing all bits would never match.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int DW       = 8;
    localparam int AW       = 3;
    localparam int NFIELD   = 4;
    localparam int RPT_BIT  = 7;
    localparam int AFE_BIT  = 7;
    localparam int ABE_BIT  = 5;
    localparam int FLAG_BIT = 6;

    localparam logic [AW-1:0] A_SEC  = 3'd0;
    localparam logic [AW-1:0] A_MIN  = 3'd1;
    localparam logic [AW-1:0] A_HOUR = 3'd2;
    localparam logic [AW-1:0] A_DAY  = 3'd3;
    localparam logic [AW-1:0] A_CTL  = 3'd4;
    localparam logic [AW-1:0] A_STAT = 3'd5;

    typedef struct packed {
        logic [NFIELD-1:0][DW-1:0] alm;
        logic                      afe;
        logic                      abe;
    } alarm_cfg_t;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          flag_i,
    output alarm_cfg_t    cfg_o,
    output logic [DW-1:0] rdata_o,
    output logic          stat_rd_o
);
    typedef struct packed {
        alarm_cfg_t    cfg;
        logic [DW-1:0] rdata;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (addr_i)
                A_SEC, A_MIN, A_HOUR, A_DAY: st_d.cfg.alm[addr_i[1:0]] = wdata_i;
                A_CTL: begin
                    st_d.cfg.afe = wdata_i[AFE_BIT];
                    st_d.cfg.abe = wdata_i[ABE_BIT];
                end
                default: ;
            endcase
        end
        if (rd_i) begin
            st_d.rdata = '0;
            case (addr_i)
                A_SEC, A_MIN, A_HOUR, A_DAY: st_d.rdata = st_q.cfg.alm[addr_i[1:0]];
                A_CTL: begin
                    st_d.rdata[AFE_BIT] = st_q.cfg.afe;
                    st_d.rdata[ABE_BIT] = st_q.cfg.abe;
                end
                A_STAT: st_d.rdata[FLAG_BIT] = flag_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o     = st_q.cfg;
    assign rdata_o   = st_q.rdata;
    assign stat_rd_o = rd_i && (addr_i == A_STAT);

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_CTL) |=> (cfg_o.afe == $past(wdata_i[AFE_BIT])));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i) |=> $stable(rdata_o));
endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
#(
    parameter int SEC_W  = 7,
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 6,
    parameter int DAY_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_i,
    input  logic                      batt_i,
    input  logic [NFIELD-1:0][DW-1:0] cur_i,
    input  alarm_cfg_t                cfg_i,
    output logic                      fire_o
);
    logic [NFIELD-1:0] hit;
    logic [NFIELD-1:0] unused_pad;
    logic              rpt_all;

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        localparam int W = (i == 0) ? SEC_W : (i == 1) ? MIN_W : (i == 2) ? HOUR_W : DAY_W;
        assign hit[i] = cfg_i.alm[i][RPT_BIT] || (cur_i[i][W-1:0] == cfg_i.alm[i][W-1:0]);
        if (W < RPT_BIT) begin : g_pad
            assign unused_pad[i] = ^{cur_i[i][DW-1:W], cfg_i.alm[i][RPT_BIT-1:W]};
        end else begin : g_nopad
            assign unused_pad[i] = ^cur_i[i][DW-1:W];
        end
    end

    assign rpt_all = cfg_i.alm[0][RPT_BIT] && cfg_i.alm[1][RPT_BIT]
                  && cfg_i.alm[2][RPT_BIT] && cfg_i.alm[3][RPT_BIT];

    assign fire_o = tick_i && (&hit) && (!batt_i || cfg_i.abe);

    // R5
    every_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && rpt_all && !batt_i) |-> fire_o);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic clr_i,
    input  logic afe_i,
    output logic flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i)     st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag && afe_i;

    // R3
    set_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> flag_o);

    // R8
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !fire_i) |=> !flag_o);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import alarm_pkg::*;
#(
    parameter int SEC_W  = 7,
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 6,
    parameter int DAY_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              batt_mode,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DAY_W-1:0]  cur_day,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              alarm_flag,
    output logic              irq
);
    alarm_cfg_t                cfg;
    logic [NFIELD-1:0][DW-1:0] cur_vec;
    logic                      fire;
    logic                      stat_rd;

    assign cur_vec[0] = {{(DW-SEC_W){1'b0}},  cur_sec};
    assign cur_vec[1] = {{(DW-MIN_W){1'b0}},  cur_min};
    assign cur_vec[2] = {{(DW-HOUR_W){1'b0}}, cur_hour};
    assign cur_vec[3] = {{(DW-DAY_W){1'b0}},  cur_day};

    alarm_regs i_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd),
        .addr_i(reg_addr), .wdata_i(reg_wdata), .flag_i(alarm_flag),
        .cfg_o(cfg), .rdata_o(reg_rdata), .stat_rd_o(stat_rd)
    );

    alarm_match #(.SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W)) i_match (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .batt_i(batt_mode),
        .cur_i(cur_vec), .cfg_i(cfg), .fire_o(fire)
    );

    alarm_flag i_flag (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .clr_i(stat_rd),
        .afe_i(cfg.afe), .flag_o(alarm_flag), .irq_o(irq)
    );

    // R4
    flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(tick));

    // R7
    batt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && batt_mode && !cfg.abe && !alarm_flag) |=> !alarm_flag);
endmodule

// File: tb/test_tod_alarm.sv
module test_tod_alarm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       batt_mode = 1'b0;
    logic [6:0] cur_sec = '0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [5:0] cur_day = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       alarm_flag;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic       flag;
        logic       irq;
        bit         chk_rd;
        logic [7:0] rd;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    tod_alarm i_tod_alarm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .batt_mode(batt_mode),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alarm_flag(alarm_flag), .irq(irq)
    );

    // monitor: compare outputs against queued expectations
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (alarm_flag !== e.flag || irq !== e.irq ||
                (e.chk_rd && reg_rdata !== e.rd)) begin
                failures++;
                $display("FAIL %s: flag/irq/rdata actual %b/%b/%h expected %b/%b/%h",
                         e.req, alarm_flag, irq, reg_rdata, e.flag, e.irq, e.rd);
            end
        end
    end

    task automatic step(input bit tk, input bit wr, input bit rd,
                        input logic [2:0] a, input logic [7:0] wd);
        @(negedge clk);
        tick = tk; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        #1;
        tick = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic expect_st(input logic f, input logic i, input bit c,
                             input logic [7:0] r, input string req);
        exp_t e;
        e.flag = f; e.irq = i; e.chk_rd = c; e.rd = r; e.req = req;
        sb.push_back(e);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] v);
        step(1'b0, 1'b1, 1'b0, a, v);
    endtask

    task automatic settime(input logic [6:0] s, input logic [6:0] m,
                           input logic [5:0] h, input logic [5:0] d);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_day = d;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 3'd0, 8'h00); expect_st(0, 0, 0, 8'h00, "R1 reset flag");
        step(0, 0, 1, 3'd4, 8'h00); expect_st(0, 0, 1, 8'h00, "R1 reset control");
        step(0, 0, 1, 3'd0, 8'h00); expect_st(0, 0, 1, 8'h00, "R1 reset alarm sec");

        wreg(3'd0, 8'h56); wreg(3'd1, 8'h34); wreg(3'd2, 8'h12); wreg(3'd3, 8'h15);
        wreg(3'd4, 8'hFF);
        step(0, 0, 1, 3'd4, 8'h00); expect_st(0, 0, 1, 8'hA0, "R2 control readback");
        wreg(3'd4, 8'h80);
        step(0, 0, 1, 3'd2, 8'h00); expect_st(0, 0, 1, 8'h12, "R2 hour readback");
        step(0, 0, 0, 3'd0, 8'h00); expect_st(0, 0, 1, 8'h12, "R2 rdata holds");

        settime(7'h55, 7'h34, 6'h12, 6'h15);
        step(1, 0, 0, 3'd0, 8'h00); expect_st(0, 0, 0, 8'h00, "R3 off-by-one second");
        settime(7'h56, 7'h34, 6'h12, 6'h15);
        step(0, 0, 0, 3'd0, 8'h00); expect_st(0, 0, 0, 8'h00, "R4 no tick");
        step(1, 0, 0, 3'd0, 8'h00); expect_st(1, 1, 0, 8'h00, "R3 full match");
        settime(7'h57, 7'h34, 6'h12, 6'h15);
        step(1, 0, 0, 3'd0, 8'h00); expect_st(1, 1, 0, 8'h00, "R9 sticky");
        step(0, 0, 1, 3'd5, 8'h00); expect_st(0, 0, 1, 8'h40, "R8 read clears");
        step(0, 0, 1, 3'd5, 8'h00); expect_st(0, 0, 1, 8'h00, "R8 second read");

        wreg(3'd0, 8'hD6);
        settime(7'h07, 7'h34, 6'h12, 6'h15);
        step(1, 0, 0, 3'd0, 8'h00); expect_st(1, 1, 0, 8'h00, "R5 seconds repeat");
        step(0, 0, 1, 3'd5, 8'h00); expect_st(0, 0, 1, 8'h40, "R8 clear");
        settime(7'h07, 7'h35, 6'h12, 6'h15);
        step(1, 0, 0, 3'd0, 8'h00); expect_st(0, 0, 0, 8'h00, "R5 minute still compared");

        wreg(3'd1, 8'hB4); wreg(3'd2, 8'h92); wreg(3'd3, 8'h95);
        settime(7'h01, 7'h02, 6'h03, 6'h04);
        step(1, 0, 0, 3'd0, 8'h00); expect_st(1, 1, 0, 8'h00, "R5 all repeat");
        step(0, 0, 1, 3'd5, 8'h00); expect_st(0, 0, 1, 8'h40, "R8 clear");

        wreg(3'd4, 8'h00);
        step(1, 0, 0, 3'd0, 8'h00); expect_st(1, 0, 0, 8'h00, "R6 irq masked");
        wreg(3'd4, 8'h80);          expect_st(1, 1, 0, 8'h00, "R6 irq unmasked");
        step(0, 0, 1, 3'd5, 8'h00); expect_st(0, 0, 1, 8'h40, "R8 clear");

        @(negedge clk); batt_mode = 1'b1;
        step(1, 0, 0, 3'd0, 8'h00); expect_st(0, 0, 0, 8'h00, "R7 battery blocks");
        wreg(3'd4, 8'hA0);
        step(1, 0, 0, 3'd0, 8'h00); expect_st(1, 1, 0, 8'h00, "R7 battery allowed");
        step(0, 0, 1, 3'd5, 8'h00); expect_st(0, 0, 1, 8'h40, "R8 clear");
        @(negedge clk); batt_mode = 1'b0;

        step(1, 0, 1, 3'd5, 8'h00); expect_st(1, 1, 1, 8'h00, "R8 set wins over read");
        step(0, 0, 1, 3'd5, 8'h00); expect_st(0, 0, 1, 8'h40, "R8 clear after collision");

        wreg(3'd0, 8'h56); wreg(3'd1, 8'h34); wreg(3'd2, 8'h52); wreg(3'd3, 8'h15);
        settime(7'h56, 7'h34, 6'h12, 6'h15);
        step(1, 0, 0, 3'd0, 8'h00); expect_st(1, 1, 0, 8'h00, "R3 hour bit6 ignored");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule